// File: doc/BRIEF.md
# Typed Status and Control Register Bank

This block is a core-side register file for a host that reaches it through a chip select, an address, single-cycle read and write strobes and a 32-bit data bus. A decoder, qualified by chip select, turns each strobe into per-register enables and a read-data select. Four storage kinds sit behind it: a read/write configuration register, an interrupt status register that clears when read, a 32-bit wrapping event counter, and a holding register that takes a snapshot of a core value when it is read.

The selected register's value is multiplexed onto the bus and latched. A one-cycle ready follows every qualified access. An address-valid flag accompanies ready when the address maps to a register. Unmapped addresses still complete, with zero data. The small registers are `REG_W` bits wide (1, 4, 8 or 16) and are zero-extended onto the bus. The counter is always 32 bits.

Top module: `typed_reg_bank`

## Requirements
- R1: After a synchronous reset, `rdata`, `ready`, `addr_valid`, `cfg_q` and `snap_q` are zero, and the counter and interrupt status read as zero.
- R2: While `cs` is low, strobes are ignored: no ready, no address-valid and no register change.
- R3: Each cycle with `cs` high and one strobe high produces `ready` high in the following cycle only. `addr_valid` is high in that cycle when the address is 0 to 3, and low otherwise. The host never raises both strobes at once.
- R4: The address map is 0 configuration, 1 interrupt status, 2 counter, 3 holding. Read data sits in the low bits of `rdata`, zero-extended, and is valid while `ready` is high.
- R5: A write to address 0 loads `wdata[REG_W-1:0]` into the configuration register, which drives `cfg_q` and reads back unchanged.
- R6: Each `irq_evt` bit sets the matching status bit, which stays set. A read returns the status and clears it. An event in the same cycle as the read stays set afterwards.
- R7: The counter adds one in each cycle `cnt_evt` is high. Reading it does not clear it. It wraps from 0xFFFFFFFF to 0.
- R8: A write to address 2 loads the counter from `wdata`. The load wins over an event in the same cycle.
- R9: A read of address 3 returns `hold_src` as sampled in the strobe cycle, and `snap_q` captures that same value. Otherwise `snap_q` does not change.
- R10: A read of an address above 3 returns all-zero data, still gives `ready`, and leaves `addr_valid` low.
- R11: Writes to addresses 1 and 3 change nothing.
- R12: `rdata` changes only on a qualified read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select that qualifies the strobes |
| addr | input | ADDR_W | Register address |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Latched read data |
| ready | output | 1 | Access-complete pulse |
| addr_valid | output | 1 | Mapped address flag, valid with ready |
| cfg_q | output | REG_W | Configuration value to the core |
| irq_evt | input | REG_W | One-cycle interrupt events |
| cnt_evt | input | 1 | Counter increment event |
| hold_src | input | REG_W | Core value sampled by a holding read |
| snap_q | output | REG_W | Value captured by the last holding read |

## Verification
The checks take for granted that the host never raises both strobes in one cycle. They also assume a strobe lasts exactly one cycle per access, so each ready maps to a single access. The stimulus draws a single operation per cycle, either a read, a write or an idle cycle. Chip select is dropped now and then, and addresses above the map are included. Event inputs are drawn freely, including in the same cycle as reads and counter loads.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int BUS_W    = 32;
  localparam int CNT_W    = 32;
  localparam int NREG     = 4;
  localparam int SEL_W    = $clog2(NREG);
  localparam int IDX_CFG  = 0;
  localparam int IDX_IRQ  = 1;
  localparam int IDX_CNT  = 2;
  localparam int IDX_HOLD = 3;
endpackage

// File: rtl/tsr_decode.sv
module tsr_decode
  import tsr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_stb,
  input  logic              rd_stb,
  output logic [NREG-1:0]   wr_en,
  output logic [NREG-1:0]   rd_en,
  output logic [SEL_W-1:0]  sel,
  output logic              hit,
  output logic              latch_en,
  output logic              access
);
  // mapped addresses occupy the lowest NREG locations
  assign hit      = cs && (addr[ADDR_W-1:SEL_W] == '0);
  assign sel      = addr[SEL_W-1:0];
  assign latch_en = cs && rd_stb;
  assign access   = cs && (rd_stb || wr_stb);

  for (genvar i = 0; i < NREG; i++) begin : g_en
    assign wr_en[i] = hit && wr_stb && (sel == SEL_W'(i));
    assign rd_en[i] = hit && rd_stb && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/tsr_storage.sv
module tsr_storage
  import tsr_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREG-1:0]  wr_en,
  input  logic [NREG-1:0]  rd_en,
  input  logic [BUS_W-1:0] wdata,
  input  logic [REG_W-1:0] irq_evt,
  input  logic             cnt_evt,
  input  logic [REG_W-1:0] hold_src,
  output logic [REG_W-1:0] cfg_q,
  output logic [REG_W-1:0] irq_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [REG_W-1:0] snap_q
);
  // configuration: plain read/write
  always_ff @(posedge clk) begin
    if (rst)                 cfg_q <= '0;
    else if (wr_en[IDX_CFG]) cfg_q <= wdata[REG_W-1:0];
  end

  // interrupt status: sticky, cleared by a read, new events win
  logic [REG_W-1:0] irq_keep;
  assign irq_keep = rd_en[IDX_IRQ] ? '0 : irq_q;
  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_keep | irq_evt;
  end

  // event counter: load has priority, natural wrap on overflow
  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (wr_en[IDX_CNT]) cnt_q <= wdata[CNT_W-1:0];
    else if (cnt_evt)        cnt_q <= cnt_q + CNT_W'(1);
  end

  // holding register: snapshot taken in the read cycle
  always_ff @(posedge clk) begin
    if (rst)                  snap_q <= '0;
    else if (rd_en[IDX_HOLD]) snap_q <= hold_src;
  end
endmodule

// File: rtl/tsr_rdport.sv
module tsr_rdport
  import tsr_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] cfg_q,
  input  logic [REG_W-1:0] irq_q,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [REG_W-1:0] hold_src,
  input  logic [SEL_W-1:0] sel,
  input  logic             hit,
  input  logic             latch_en,
  input  logic             access,
  output logic [BUS_W-1:0] rdata,
  output logic             ready,
  output logic             addr_valid
);
  logic [NREG-1:0][BUS_W-1:0] src;
  logic [BUS_W-1:0]           mux_out;

  always_comb begin
    src           = '0;
    src[IDX_CFG]  = BUS_W'(cfg_q);
    src[IDX_IRQ]  = BUS_W'(irq_q);
    src[IDX_CNT]  = BUS_W'(cnt_q);
    src[IDX_HOLD] = BUS_W'(hold_src);
    mux_out       = hit ? src[sel] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata      <= '0;
      ready      <= 1'b0;
      addr_valid <= 1'b0;
    end else begin
      if (latch_en) rdata <= mux_out;
      ready      <= access;
      addr_valid <= access && hit;
    end
  end
endmodule

// File: rtl/typed_reg_bank.sv
module typed_reg_bank
  import tsr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              ready,
  output logic              addr_valid,
  output logic [REG_W-1:0]  cfg_q,
  input  logic [REG_W-1:0]  irq_evt,
  input  logic              cnt_evt,
  input  logic [REG_W-1:0]  hold_src,
  output logic [REG_W-1:0]  snap_q
);
  logic [NREG-1:0]  wr_en, rd_en;
  logic [SEL_W-1:0] sel;
  logic             hit, latch_en, access;
  logic [REG_W-1:0] irq_q;
  logic [CNT_W-1:0] cnt_q;

  tsr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cs(cs), .addr(addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_en(wr_en), .rd_en(rd_en), .sel(sel), .hit(hit),
    .latch_en(latch_en), .access(access)
  );

  tsr_storage #(.REG_W(REG_W)) u_sto (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .irq_evt(irq_evt), .cnt_evt(cnt_evt), .hold_src(hold_src),
    .cfg_q(cfg_q), .irq_q(irq_q), .cnt_q(cnt_q), .snap_q(snap_q)
  );

  tsr_rdport #(.REG_W(REG_W)) u_rdp (
    .clk(clk), .rst(rst), .cfg_q(cfg_q), .irq_q(irq_q), .cnt_q(cnt_q),
    .hold_src(hold_src), .sel(sel), .hit(hit), .latch_en(latch_en),
    .access(access), .rdata(rdata), .ready(ready), .addr_valid(addr_valid)
  );
endmodule

// File: rtl/typed_reg_bank_chk.sv
module typed_reg_bank_chk
  import tsr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              ready,
  input logic              addr_valid,
  input logic [REG_W-1:0]  cfg_q,
  input logic [REG_W-1:0]  irq_evt,
  input logic              cnt_evt,
  input logic [REG_W-1:0]  hold_src,
  input logic [REG_W-1:0]  snap_q
);
  logic acc, unmapped, cfg_wr, hold_rd;
  assign acc      = cs && (rd_stb || wr_stb);
  assign unmapped = addr[ADDR_W-1:SEL_W] != '0;
  assign cfg_wr   = cs && wr_stb && (addr == ADDR_W'(IDX_CFG));
  assign hold_rd  = cs && rd_stb && (addr == ADDR_W'(IDX_HOLD));

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && wr_stb)); // R3
  AST_NO_CS: assert property (@(posedge clk) disable iff (rst)
    !cs |=> (!ready && !addr_valid)); // R2
  AST_READY_ACC: assert property (@(posedge clk) disable iff (rst)
    acc |=> ready); // R3
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !ready); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cs && rd_stb && unmapped) |=> (rdata == '0 && ready && !addr_valid)); // R10
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> cfg_q == $past(wdata[REG_W-1:0])); // R5
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(cfg_q)); // R5
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (rst)
    hold_rd |=> (snap_q == $past(hold_src) && rdata == 32'($past(hold_src)))); // R9
  AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (rst)
    !hold_rd |=> $stable(snap_q)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd_stb) |=> $stable(rdata)); // R12
endmodule

bind typed_reg_bank typed_reg_bank_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/typed_reg_bank_tb.sv
module typed_reg_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, cnt_evt = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          ready, addr_valid;
  logic [RW-1:0] cfg_q, snap_q;
  logic [RW-1:0] irq_evt = '0, hold_src = '0;

  int n_run = 0, n_fail = 0;
  logic [RW-1:0] m_cfg = '0, m_irq = '0, m_snap = '0;
  logic [31:0]   m_cnt = '0, m_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  typed_reg_bank #(.ADDR_W(AW), .REG_W(RW)) u_dut (
    .clk(clk), .rst(rst), .cs(cs), .addr(addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wdata(wdata), .rdata(rdata), .ready(ready), .addr_valid(addr_valid),
    .cfg_q(cfg_q), .irq_evt(irq_evt), .cnt_evt(cnt_evt), .hold_src(hold_src),
    .snap_q(snap_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [AW-1:0] a, input logic [RW-1:0] hs);
    case (a)
      3'd0:    return 32'(m_cfg);
      3'd1:    return 32'(m_irq);
      3'd2:    return m_cnt;
      3'd3:    return 32'(hs);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [AW-1:0] a);
    case (a)
      3'd0:    return "R4 R5 cfg read";
      3'd1:    return "R6 irq read";
      3'd2:    return "R7 counter read";
      3'd3:    return "R9 hold read";
      default: return "R10 unmapped read";
    endcase
  endfunction

  // one bus cycle: drive at negedge, edge, compare at next negedge
  task automatic step(input bit c, input bit r, input bit w, input logic [AW-1:0] a,
                      input logic [31:0] wd, input logic [RW-1:0] ie, input bit ce,
                      input logic [RW-1:0] hs);
    bit acc, mapped, rd_q;
    acc    = c && (r || w);
    mapped = (a < 3'd4);
    rd_q   = c && r;
    cs = c; rd_stb = r; wr_stb = w; addr = a; wdata = wd;
    irq_evt = ie; cnt_evt = ce; hold_src = hs;
    if (rd_q) m_rdata = model_read(a, hs);
    if (c && w && a == 3'd0) m_cfg = wd[RW-1:0];
    m_irq = ((rd_q && a == 3'd1) ? '0 : m_irq) | ie;
    if (c && w && a == 3'd2) m_cnt = wd;
    else if (ce)             m_cnt = m_cnt + 32'd1;
    if (rd_q && a == 3'd3)   m_snap = hs;
    @(negedge clk);
    cs = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0; irq_evt = '0; cnt_evt = 1'b0;
    if (!c) begin
      chk("R2 ready with cs low", 32'(ready), 32'd0);
      chk("R2 cfg with cs low", 32'(cfg_q), 32'(m_cfg));
    end else begin
      chk("R3 ready", 32'(ready), 32'(acc));
      chk(mapped ? "R3 addr_valid" : "R10 addr_valid", 32'(addr_valid), 32'(acc && mapped));
    end
    chk(rd_q ? rd_tag(a) : "R12 rdata held", rdata, m_rdata);
    chk("R5 cfg_q", 32'(cfg_q), 32'(m_cfg));
    chk("R9 snap_q", 32'(snap_q), 32'(m_snap));
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [RW-1:0] ie = '0,
                    input logic [RW-1:0] hs = '0);
    step(1, 1, 0, a, 32'd0, ie, 0, hs);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input bit ce = 0);
    step(1, 0, 1, a, d, '0, ce, '0);
  endtask

  task automatic idle(input logic [RW-1:0] ie = '0, input bit ce = 0);
    step(1, 0, 0, 3'd0, 32'd0, ie, ce, '0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED_0042;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 rdata", rdata, 32'd0);
    chk("R1 ready", 32'(ready), 32'd0);
    chk("R1 addr_valid", 32'(addr_valid), 32'd0);
    chk("R1 cfg_q", 32'(cfg_q), 32'd0);
    chk("R1 snap_q", 32'(snap_q), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    rd(3'd2);                           // R1 counter zero
    rd(3'd1);                           // R1 irq zero
    // R5 configuration
    wr(3'd0, 32'h0000_00A5);
    rd(3'd0);
    // R2 strobes ignored without chip select
    step(0, 0, 1, 3'd0, 32'h3C, '0, 0, '0);
    step(0, 1, 0, 3'd3, 32'd0, '0, 0, 8'h77);
    rd(3'd0);
    // R6 interrupt status
    idle(8'h05);
    idle(8'h10);
    rd(3'd1);
    rd(3'd1);
    idle(8'h03);
    rd(3'd1, 8'h80);                    // event in read cycle survives
    rd(3'd1);
    // R7 counter
    idle('0, 1); idle('0, 1); idle('0, 1);
    rd(3'd2);
    rd(3'd2);                           // no clear on read
    wr(3'd2, 32'hFFFF_FFFE);            // R8 preload
    idle('0, 1); idle('0, 1);           // wraps to zero
    rd(3'd2);
    wr(3'd2, 32'h0000_0010, 1);         // R8 load wins over event
    rd(3'd2);
    // R9 holding snapshot
    rd(3'd3, '0, 8'h5A);
    idle();
    rd(3'd3, '0, 8'hC3);
    // R10 unmapped
    rd(3'd5);
    wr(3'd7, 32'hFFFF_FFFF);
    // R11 writes to read-only kinds
    idle(8'h01);
    wr(3'd1, 32'hFF);
    rd(3'd1);
    wr(3'd3, 32'hFF);
    rd(3'd0);
    // random phase
    for (int i = 0; i < 600; i++) begin
      bit c, r, w;
      int op;
      c  = ($urandom % 8) != 0;
      op = $urandom % 3;
      r  = (op == 0);
      w  = (op == 1);
      step(c, r, w, AW'($urandom), $urandom, RW'($urandom & $urandom), 1'($urandom),
           RW'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule